// File: doc/BRIEF.md
# Two-Way Locking Instruction Cache

A read-only instruction cache sits between a CPU fetch port and an external memory that returns data in bursts. It holds 1 KB of code in two ways of 32 sets each. Every line carries four 32-bit words. Each line has a tag, a valid bit and a lock bit. A locked line is never chosen for replacement, so code placed in the cache while locking is enabled stays resident.

The CPU sends one fetch at a time. `req_i` is a single-cycle pulse that is accepted while `ready_o` is high, and the CPU then waits for `rvalid_o`. A hit answers in the next cycle. A miss sends a one-cycle line request to memory. Memory returns the four words of the line in order, and the cache returns the requested word as soon as its beat arrives. The cache takes no new fetch until the whole line has been received.

Side inputs control the cache contents. They can invalidate every line, clear every lock, lock the lines being filled, or turn the cache off. With the cache off, every fetch goes to memory and nothing is allocated.

Top module: `instr_cache_2w`

## Requirements
- R1: After reset `ready_o`=1, `rvalid_o`=0 and `mem_req_o`=0, and no line is valid, so the first fetch misses.
- R2: The fetch address is split into three fields. Bits [3:2] select the word, bits [8:4] select the set, and bits [31:9] form the tag; bits [1:0] are ignored. A hit accepted in cycle t raises `rvalid_o` in cycle t+1 with the stored word and issues no memory request.
- R3: A miss raises `mem_req_o` for one cycle, with `mem_addr_o` equal to the fetch address with bits [3:0] cleared. The next four `mem_valid_i` beats carry words 0 to 3 of the line. `rvalid_o` rises in the cycle after the beat whose index equals the requested word, and `ready_o` stays low until the cycle after beat 3.
- R4: On a miss, an invalid unlocked way is filled first, with way 0 taken before way 1. If no such way exists, the least recently used unlocked way is replaced. Both hits and fills count as use.
- R5: A line filled while `lock_fill_i`=1 becomes locked, and a locked way is never replaced.
- R6: When both ways of a set are locked, a miss is still served from memory but no line is allocated, so a repeat of the fetch misses again.
- R7: `inv_all_i` clears every valid bit and leaves every lock bit unchanged.
- R8: `unlock_all_i` clears every lock bit.
- R9: While `enable_i`=0, every fetch is served from memory as a miss and allocates nothing. Lines already stored remain intact.
- R10: A tag is present in at most one way of a set, so at most one way hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | 1 = cache active, 0 = every fetch goes to memory |
| inv_all_i | input | 1 | Clear all valid bits |
| unlock_all_i | input | 1 | Clear all lock bits |
| lock_fill_i | input | 1 | Lock lines allocated by the current miss |
| req_i | input | 1 | Fetch request pulse |
| addr_i | input | 32 | Fetch byte address |
| ready_o | output | 1 | A fetch can be accepted |
| rvalid_o | output | 1 | Fetched word valid |
| rdata_o | output | 32 | Fetched word |
| mem_req_o | output | 1 | Line read request, one cycle |
| mem_addr_o | output | 32 | Line-aligned read address |
| mem_valid_i | input | 1 | Memory beat valid |
| mem_rdata_i | input | 32 | Memory beat data |

## Verification
Some properties are checked on every cycle. At most one way hits. A hit is answered in the next cycle. A victim is never locked. Invalidate leaves no valid line, unlock leaves no lock, and no line request is issued while the port is ready. Other behaviours only show up over a sequence of fetches, so the bench's scenarios are the only evidence for them. These are the order of least-recently-used eviction, a locked line surviving eviction pressure, locks that persist after invalidation, sets where both ways are locked and nothing is allocated, and the disabled mode leaving the stored contents untouched.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2
  } fsm_e;

  localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/icache_way.sv
module icache_way #(
  parameter int unsigned SETS   = 32,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned TAG_W  = 23,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned OFF_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  lk_set_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [OFF_W-1:0]  lk_word_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o,
  output logic              lock_o,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [OFF_W-1:0]  wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inst_i,
  input  logic [TAG_W-1:0]  inst_tag_i,
  input  logic              inst_lock_i,
  input  logic              inv_all_i,
  input  logic              unlock_all_i,
  output logic              valid_any_o,
  output logic              lock_any_o
);
  logic [SETS-1:0]   valid_q, lock_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS*WORDS];

  assign valid_o     = valid_q[lk_set_i];
  assign lock_o      = lock_q[lk_set_i];
  assign hit_o       = valid_q[lk_set_i] && (tag_q[lk_set_i] == lk_tag_i);
  assign rdata_o     = data_q[{lk_set_i, lk_word_i}];
  assign valid_any_o = |valid_q;
  assign lock_any_o  = |lock_q;

  // invalidate and unlock win over a concurrent install
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lock_q  <= '0;
    end else begin
      if (inst_i) begin
        valid_q[wr_set_i] <= 1'b1;
        lock_q[wr_set_i]  <= inst_lock_i;
      end
      if (inv_all_i)    valid_q <= '0;
      if (unlock_all_i) lock_q  <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (inst_i) tag_q[wr_set_i] <= inst_tag_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[{wr_set_i, wr_word_i}] <= wr_data_i;
  end
endmodule

// File: rtl/icache_victim.sv
module icache_victim (
  input  logic [1:0] valid_i,
  input  logic [1:0] lock_i,
  input  logic       lru_i,
  output logic       way_o,
  output logic       ok_o
);
  logic [1:0] free;
  assign free = ~lock_i;

  always_comb begin
    ok_o  = 1'b1;
    way_o = 1'b0;
    if (free[0] && !valid_i[0])      way_o = 1'b0;
    else if (free[1] && !valid_i[1]) way_o = 1'b1;
    else if (&free)                  way_o = lru_i;
    else if (free[0])                way_o = 1'b0;
    else if (free[1])                way_o = 1'b1;
    else                             ok_o  = 1'b0;
  end
endmodule

// File: rtl/instr_cache_2w.sv
module instr_cache_2w
  import icache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 32,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              inv_all_i,
  input  logic              unlock_all_i,
  input  logic              lock_fill_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(WORDS * 4 - 1));
  localparam logic [OFF_W-1:0]  LAST_BEAT = OFF_W'(WORDS - 1);

  logic [OFF_W-1:0] lk_word, off_q, beat_q;
  logic [SET_W-1:0] lk_set, set_q;
  logic [TAG_W-1:0] lk_tag, tag_q;

  fsm_e              state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              victim_q, alloc_q, lock_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic [SETS-1:0]   lru_q;  // way to evict next

  logic [NUM_WAYS-1:0] hit_vec, way_valid, way_lock, valid_any, lock_any;
  logic [NUM_WAYS-1:0] way_inst, way_wr;
  logic [DATA_W-1:0]   way_rdata [NUM_WAYS];

  logic hit_any, hit_way, vic_way, vic_ok, fill_beat, fill_last;

  assign lk_word = addr_i[2 +: OFF_W];
  assign lk_set  = addr_i[2+OFF_W +: SET_W];
  assign lk_tag  = addr_i[ADDR_W-1 -: TAG_W];
  assign off_q   = addr_q[2 +: OFF_W];
  assign set_q   = addr_q[2+OFF_W +: SET_W];
  assign tag_q   = addr_q[ADDR_W-1 -: TAG_W];

  assign hit_any   = enable_i && (|hit_vec);
  assign hit_way   = hit_vec[1];
  assign fill_beat = (state_q == ST_FILL) && mem_valid_i;
  assign fill_last = fill_beat && (beat_q == LAST_BEAT);

  assign ready_o    = (state_q == ST_IDLE);
  assign rvalid_o   = rvalid_q;
  assign rdata_o    = rdata_q;
  assign mem_req_o  = (state_q == ST_ISSUE);
  assign mem_addr_o = addr_q & LINE_MASK;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_wr[w]   = fill_beat && alloc_q && (victim_q == 1'(w));
    assign way_inst[w] = fill_last && alloc_q && (victim_q == 1'(w));

    icache_way #(
      .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_way (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lk_set_i     (lk_set),
      .lk_tag_i     (lk_tag),
      .lk_word_i    (lk_word),
      .hit_o        (hit_vec[w]),
      .rdata_o      (way_rdata[w]),
      .valid_o      (way_valid[w]),
      .lock_o       (way_lock[w]),
      .wr_en_i      (way_wr[w]),
      .wr_set_i     (set_q),
      .wr_word_i    (beat_q),
      .wr_data_i    (mem_rdata_i),
      .inst_i       (way_inst[w]),
      .inst_tag_i   (tag_q),
      .inst_lock_i  (lock_q),
      .inv_all_i    (inv_all_i),
      .unlock_all_i (unlock_all_i),
      .valid_any_o  (valid_any[w]),
      .lock_any_o   (lock_any[w])
    );
  end

  icache_victim u_victim (
    .valid_i (way_valid),
    .lock_i  (way_lock),
    .lru_i   (lru_q[lk_set]),
    .way_o   (vic_way),
    .ok_o    (vic_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      beat_q   <= '0;
      victim_q <= 1'b0;
      alloc_q  <= 1'b0;
      lock_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      lru_q    <= '0;
    end else begin
      rvalid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            addr_q <= addr_i;
            if (hit_any) begin
              rvalid_q      <= 1'b1;
              rdata_q       <= way_rdata[hit_way];
              lru_q[lk_set] <= ~hit_way;
            end else begin
              victim_q <= vic_way;
              alloc_q  <= enable_i && vic_ok;
              lock_q   <= lock_fill_i;
              state_q  <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          beat_q  <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_valid_i) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == off_q) begin
              rvalid_q <= 1'b1;
              rdata_q  <= mem_rdata_i;
            end
            if (beat_q == LAST_BEAT) begin
              state_q <= ST_IDLE;
              if (alloc_q) lru_q[set_q] <= ~victim_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icache_chk.sv
module icache_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       ready_o,
  input logic       rvalid_o,
  input logic       mem_req_o,
  input logic       inv_all_i,
  input logic       unlock_all_i,
  input logic       hit_any,
  input logic [1:0] hit_vec,
  input logic       vic_ok,
  input logic       vic_way,
  input logic [1:0] way_lock,
  input logic [1:0] valid_any,
  input logic [1:0] lock_any
);
  p_single_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_hit_next_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && hit_any) |=> rvalid_o);

  p_no_locked_victim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !hit_any && vic_ok) |-> !way_lock[vic_way]);

  p_inv_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (valid_any == 2'b00));

  p_unlock_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_all_i |=> (lock_any == 2'b00));

  p_req_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);
endmodule

bind instr_cache_2w icache_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ready_o      (ready_o),
  .rvalid_o     (rvalid_o),
  .mem_req_o    (mem_req_o),
  .inv_all_i    (inv_all_i),
  .unlock_all_i (unlock_all_i),
  .hit_any      (hit_any),
  .hit_vec      (hit_vec),
  .vic_ok       (vic_ok),
  .vic_way      (vic_way),
  .way_lock     (way_lock),
  .valid_any    (valid_any),
  .lock_any     (lock_any)
);

// File: tb/instr_cache_2w_test.sv
module instr_cache_2w_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {address, miss expected}
  localparam logic [32:0] VEC [NVEC] = '{
    {32'h0000_0004, 1'b1}, {32'h0000_000C, 1'b0}, {32'h0000_0200, 1'b1},
    {32'h0000_0008, 1'b0}, {32'h0000_0400, 1'b1}, {32'h0000_0000, 1'b0},
    {32'h0000_0204, 1'b1}, {32'h0000_0404, 1'b1}, {32'h0000_0208, 1'b0},
    {32'h0000_000C, 1'b1}, {32'h0000_0014, 1'b1}, {32'h0000_001C, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, inv_all = 1'b0, unlock_all = 1'b0, lock_fill = 1'b0;
  logic req = 1'b0;
  logic [31:0] addr = '0;
  logic ready, rvalid, mem_req, mem_valid = 1'b0;
  logic [31:0] rdata, mem_addr, mem_rdata = '0, mbase = '0;
  int mcnt = 0, nreq = 0, errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_cache_2w uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .inv_all_i(inv_all),
    .unlock_all_i(unlock_all), .lock_fill_i(lock_fill), .req_i(req), .addr_i(addr),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h1357_9BDF;
  endfunction

  // memory model: beats follow the request by two cycles, in word order
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      nreq  <= nreq + 1;
      mbase <= mem_addr;
      mcnt  <= 1;
      mem_valid <= 1'b0;
    end else if (mcnt != 0) begin
      mem_valid <= 1'b1;
      mem_rdata <= word_of(mbase + 32'(4 * (mcnt - 1)));
      mcnt      <= (mcnt == 4) ? 0 : mcnt + 1;
    end else begin
      mem_valid <= 1'b0;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // fetch one word; checks data, miss/hit, and optionally the ready level at rvalid
  task automatic fetch(input logic [31:0] a, input logic exp_miss, input string rq,
                       input bit chk_rdy);
    int n0, t;
    logic [31:0] q;
    logic rdy;
    t = 0;
    while (!ready && t < 50) begin @(negedge clk); t++; end
    n0 = nreq;
    addr = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    t = 0;
    while (!rvalid && t < 50) begin @(negedge clk); t++; end
    q = rdata; rdy = ready;
    check({rq, " data"}, q, word_of(a));
    check({rq, " miss"}, 32'(nreq - n0), 32'(exp_miss));
    if (chk_rdy) check("R3 ready at rvalid", 32'(rdy), 32'(a[3:2] == 2'b11));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", 32'(ready), 32'd1);
    check("R1 rvalid", 32'(rvalid), 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4: fills, hits and LRU order
    for (int i = 0; i < NVEC; i++)
      fetch(VEC[i][32:1], VEC[i][0], "R2/R3/R4/R10 table", VEC[i][0]);

    // R3: line request address is line aligned
    begin
      logic [31:0] la;
      addr = 32'h0000_1E7C; req = 1'b1;
      @(negedge clk); req = 1'b0;
      @(negedge clk);
      la = mem_addr;
      check("R3 line addr", la, 32'h0000_1E70);
      while (!rvalid) @(negedge clk);
      check("R3 word", rdata, word_of(32'h0000_1E7C));
    end

    // R5 R6: both ways of set 2 locked
    lock_fill = 1'b1;
    fetch(32'h0000_0020, 1'b1, "R5 lock fill a", 0);
    fetch(32'h0000_0220, 1'b1, "R5 lock fill b", 0);
    lock_fill = 1'b0;
    fetch(32'h0000_0420, 1'b1, "R6 no alloc first", 0);
    fetch(32'h0000_0424, 1'b1, "R6 no alloc repeat", 0);
    fetch(32'h0000_0020, 1'b0, "R5 locked kept a", 0);
    fetch(32'h0000_0228, 1'b0, "R5 locked kept b", 0);

    // R4 R5: one way locked; LRU points at it but it must be skipped
    lock_fill = 1'b1;
    fetch(32'h0000_0030, 1'b1, "R5 lock one", 0);
    lock_fill = 1'b0;
    fetch(32'h0000_0230, 1'b1, "R4 fill free way", 0);
    fetch(32'h0000_0234, 1'b0, "R4 hit", 0);
    fetch(32'h0000_0430, 1'b1, "R5 evict unlocked", 0);
    fetch(32'h0000_0034, 1'b0, "R5 locked survives", 0);
    fetch(32'h0000_0238, 1'b1, "R5 unlocked evicted", 0);

    // R7: invalidate keeps locks
    @(negedge clk); inv_all = 1'b1; @(negedge clk); inv_all = 1'b0;
    fetch(32'h0000_0014, 1'b1, "R7 invalidated", 0);
    fetch(32'h0000_0020, 1'b1, "R7 locked set miss", 0);
    fetch(32'h0000_0020, 1'b1, "R7 locks kept", 0);

    // R8: unlock all
    @(negedge clk); unlock_all = 1'b1; @(negedge clk); unlock_all = 1'b0;
    fetch(32'h0000_0020, 1'b1, "R8 refill", 0);
    fetch(32'h0000_0024, 1'b0, "R8 allocated", 0);

    // R9: disabled cache
    enable = 1'b0;
    fetch(32'h0000_0014, 1'b1, "R9 bypass cached", 0);
    fetch(32'h0000_0050, 1'b1, "R9 bypass new", 0);
    enable = 1'b1;
    fetch(32'h0000_0050, 1'b1, "R9 no alloc", 0);
    fetch(32'h0000_0018, 1'b0, "R9 contents kept", 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule